// File: doc/BRIEF.md
# Seconds Counter with Match Interrupt

This block keeps a 32-bit count of seconds for a peripheral bus. The seconds reference is a slow square wave that arrives with no phase relation to the bus clock. The block brings it into the bus clock domain and filters it. It then advances the count once for each rising edge it accepts.

Software can read the count and can preset it through a load register. It also programs a match value. The block latches a pending flag whenever a fresh count value equals the match value. A mask bit decides whether that flag drives the interrupt line. Software acknowledges the flag by writing a one to bit 0 of the clear register.

Accesses use a simple two-phase peripheral-bus slave. A write commits on the clock edge where `psel_i`, `penable_i` and `pwrite_i` are all high. Read data is driven combinationally from `paddr_i` whenever `psel_i` is high.

Top module: `rtc_core`

## Requirements
- R1: After `rst_ni` goes low, the count, the load register, the match value, the mask, the pending flag and `irq_o` all read as zero.
- R2: The count goes up by exactly one for each accepted tick, and it wraps from 0xFFFFFFFF to 0x00000000.
- R3: The pending flag is bit 0 of the status register at offset 0x0C. It is set one clock after the count takes a new value, by tick or by load, when that value equals the match value at offset 0x08.
- R4: A write to offset 0x04 puts the written value in the count on the same clock edge. If a tick update falls on that edge, the load wins and the tick is lost.
- R5: A rising edge on `tick_i` changes the count on the fourth rising bus clock edge after it. A high pulse on `tick_i` that lasts only one bus cycle is ignored. A high level held for any length gives a single increment.
- R6: The pending flag is not set again while the count stays unchanged, even if it still equals the match value. Writing a match value equal to the current count does not set the flag.
- R7: `irq_o` is high only while both the pending flag and bit 0 of the mask register at offset 0x10 are high. The mask has no effect on the status read-back.
- R8: Writing a one to bit 0 of offset 0x14 clears the pending flag, and writing a zero there has no effect. If a set and a clear land on the same edge, the set wins. Offset 0x14 reads as zero.
- R9: Offset 0x00 returns the current count and ignores writes. Offset 0x04 reads back the last value loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 Hz seconds reference, asynchronous to the bus clock |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 5 | Byte address; bits 1:0 must be zero |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data |
| irq_o | output | 1 | Masked match interrupt |

## Verification
The count is the only state that persists, so an error in it, whether a lost tick or a doubled one, stays visible at offset 0x00 from then on. It also moves the interrupt by one or more seconds. A fault in the edge filter shows as a count that is off after a glitch, or that gains more than one step during a long high level. This is visible within a few bus cycles. A fault in the pending latch shows one cycle after an update, as a wrong status bit or a wrong `irq_o`. A latch that sets again while the count stays equal shows as the flag returning after a clear with no tick in between.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  localparam logic [IDX_W-1:0] IDX_COUNT = 3'd0;
  localparam logic [IDX_W-1:0] IDX_LOAD  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_MATCH = 3'd2;
  localparam logic [IDX_W-1:0] IDX_STAT  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_MASK  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_CLR   = 3'd5;
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             conf_q;
  logic                   lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], tick_i};
  end

  assign lvl = sync_q[SYNC_STAGES-1];

  // level must be seen on two consecutive edges; one pulse per rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conf_q <= '0;
    else         conf_q <= {conf_q[0], lvl};
  end

  assign pulse_o = lvl & conf_q[0] & ~conf_q[1];
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         upd_o
);
  logic [W-1:0] cnt_q;
  logic         upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= load_i | tick_i;
      if (load_i)      cnt_q <= load_val_i;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/rtc_match_irq.sv
module rtc_match_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] match_i,
  input  logic         upd_i,
  input  logic         clr_i,
  input  logic         mask_i,
  output logic         raw_o,
  output logic         irq_o
);
  logic raw_q;
  logic hit;

  assign hit = upd_i && (cnt_i == match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    raw_q <= 1'b0;
    else if (hit)   raw_q <= 1'b1;
    else if (clr_i) raw_q <= 1'b0;
  end

  assign raw_o = raw_q;
  assign irq_o = raw_q & mask_i;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [CNT_W-1:0]  pwdata_i,
  output logic [CNT_W-1:0]  prdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              raw_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CNT_W-1:0]  match_o,
  output logic              mask_o,
  output logic              clr_o
);
  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             wr;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] match_q;
  logic             mask_q;

  assign idx     = paddr_i[ADDR_W-1:2];
  assign aligned = (paddr_i[1:0] == 2'b00);
  assign wr      = psel_i & penable_i & pwrite_i & aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q  <= '0;
      match_q <= '0;
      mask_q  <= 1'b0;
    end else if (wr) begin
      case (idx)
        IDX_LOAD:  load_q  <= pwdata_i;
        IDX_MATCH: match_q <= pwdata_i;
        IDX_MASK:  mask_q  <= pwdata_i[0];
        default: ;
      endcase
    end
  end

  assign load_o     = wr && (idx == IDX_LOAD);
  assign load_val_o = pwdata_i;
  assign clr_o      = wr && (idx == IDX_CLR) && pwdata_i[0];
  assign match_o    = match_q;
  assign mask_o     = mask_q;

  always_comb begin
    prdata_o = '0;
    if (psel_i && aligned) begin
      case (idx)
        IDX_COUNT: prdata_o = cnt_i;
        IDX_LOAD:  prdata_o = load_q;
        IDX_MATCH: prdata_o = match_q;
        IDX_STAT:  prdata_o = {{(CNT_W-1){1'b0}}, raw_i};
        IDX_MASK:  prdata_o = {{(CNT_W-1){1'b0}}, mask_q};
        default:   prdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [CNT_W-1:0]  pwdata_i,
  output logic [CNT_W-1:0]  prdata_o,
  output logic              irq_o
);
  logic             tick_pulse;
  logic             load_en;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;
  logic             upd_q;
  logic [CNT_W-1:0] match_q;
  logic             mask_q;
  logic             clr;
  logic             raw_q;

  rtc_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .pulse_o(tick_pulse)
  );

  rtc_counter #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_pulse),
    .load_i    (load_en),
    .load_val_i(load_val),
    .cnt_o     (cnt_q),
    .upd_o     (upd_q)
  );

  rtc_match_irq #(.W(CNT_W)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt_q),
    .match_i(match_q),
    .upd_i  (upd_q),
    .clr_i  (clr),
    .mask_i (mask_q),
    .raw_o  (raw_q),
    .irq_o  (irq_o)
  );

  rtc_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pwdata_i  (pwdata_i),
    .prdata_o  (prdata_o),
    .cnt_i     (cnt_q),
    .raw_i     (raw_q),
    .load_o    (load_en),
    .load_val_o(load_val),
    .match_o   (match_q),
    .mask_o    (mask_q),
    .clr_o     (clr)
  );
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_pulse,
  input logic         load_en,
  input logic [W-1:0] load_val,
  input logic [W-1:0] cnt_q,
  input logic         upd_q,
  input logic [W-1:0] match_q,
  input logic         mask_q,
  input logic         raw_q,
  input logic         clr,
  input logic         irq_o
);
  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_en) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  assert_load_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> (cnt_q == $past(load_val)));

  assert_one_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_pulse |=> !tick_pulse);

  assert_set_on_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_q) |-> $past(cnt_q == match_q));

  assert_set_needs_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_q) |-> $past(upd_q));

  assert_mask_gates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_q |-> !irq_o);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !upd_q) |=> !raw_q);
endmodule

bind rtc_core rtc_core_chk #(.W(rtc_pkg::CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_pulse(tick_pulse),
  .load_en   (load_en),
  .load_val  (load_val),
  .cnt_q     (cnt_q),
  .upd_q     (upd_q),
  .match_q   (match_q),
  .mask_q    (mask_q),
  .raw_q     (raw_q),
  .clr       (clr),
  .irq_o     (irq_o)
);

// File: tb/rtc_core_bench.sv
`timescale 1ns/1ps
module rtc_core_bench;
  localparam logic [4:0] A_CNT = 5'h00, A_LOAD = 5'h04, A_MATCH = 5'h08,
                         A_STAT = 5'h0C, A_MASK = 5'h10, A_CLR = 5'h14;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [4:0]  paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  rtc_core u_rtc_core (
    .clk_i, .rst_ni, .tick_i, .psel_i, .penable_i, .pwrite_i,
    .paddr_i, .pwdata_i, .prdata_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    psel_i = 1; pwrite_i = 1; paddr_i = a; pwdata_i = d; penable_i = 0;
    @(negedge clk_i); penable_i = 1;
    @(negedge clk_i); psel_i = 0; penable_i = 0; pwrite_i = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    psel_i = 1; pwrite_i = 0; paddr_i = a;
    #1 d = prdata_o;
    psel_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic tick();
    tick_i = 1; idle(6);
    tick_i = 0; idle(6);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] base;
    idle(3);
    rst_ni = 1;
    idle(2);

    // R1 reset state
    rd(A_CNT, v);   chk("R1 count", v, 0);
    rd(A_LOAD, v);  chk("R1 load", v, 0);
    rd(A_MATCH, v); chk("R1 match", v, 0);
    rd(A_STAT, v);  chk("R1 status", v, 0);
    rd(A_MASK, v);  chk("R1 mask", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);

    // R9 count register ignores writes, clear reads zero
    wr(A_CNT, 32'd55); idle(2);
    rd(A_CNT, v); chk("R9 count write ignored", v, 0);
    rd(A_CLR, v); chk("R9 clear reads zero", v, 0);

    // R5 latency: change on fourth rising edge
    tick_i = 1;
    idle(3); rd(A_CNT, v); chk("R5 not before 4th edge", v, 0);
    idle(1); rd(A_CNT, v); chk("R5 at 4th edge", v, 1);
    tick_i = 0; idle(6);

    // R5 one-cycle glitch ignored, long level counts once
    tick_i = 1; idle(1); tick_i = 0; idle(8);
    rd(A_CNT, v); chk("R5 glitch ignored", v, 1);
    tick_i = 1; idle(20); tick_i = 0; idle(6);
    rd(A_CNT, v); chk("R5 long level single step", v, 2);

    // R2/R3/R7 sweep: match k ticks after load
    for (int k = 1; k <= 6; k++) begin
      base = 32'(k) * 32'd1000;
      wr(A_LOAD, base);
      wr(A_MATCH, base + 32'(k));
      wr(A_MASK, {31'b0, k[0]});
      wr(A_CLR, 32'd1);
      idle(2);
      rd(A_LOAD, v); chk("R9 load readback", v, base);
      for (int j = 1; j <= k; j++) begin
        tick();
        rd(A_CNT, v);  chk("R2 sweep count", v, base + 32'(j));
        rd(A_STAT, v); chk("R3 sweep status", v, (j == k) ? 32'd1 : 32'd0);
        chk("R7 sweep irq", {31'b0, irq_o}, ((j == k) && k[0]) ? 32'd1 : 32'd0);
      end
    end

    // R2 wrap, R3 match at zero
    wr(A_LOAD, 32'hFFFF_FFFE);
    wr(A_MATCH, 32'd0);
    idle(2);
    wr(A_CLR, 32'd1); idle(2);
    tick();
    rd(A_CNT, v);  chk("R2 top value", v, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R3 no match at top", v, 0);
    tick();
    rd(A_CNT, v);  chk("R2 wrap to zero", v, 0);
    rd(A_STAT, v); chk("R3 match after wrap", v, 1);

    // R6 no re-set while count stays equal
    wr(A_CLR, 32'd1); idle(10);
    rd(A_STAT, v); chk("R6 stays clear", v, 0);
    wr(A_MATCH, 32'd0); idle(4);
    rd(A_STAT, v); chk("R6 match write no set", v, 0);
    wr(A_LOAD, 32'd0); idle(2);
    rd(A_STAT, v); chk("R3 load update sets", v, 1);

    // R7 mask does not alter status
    wr(A_MASK, 32'd0); idle(1);
    rd(A_STAT, v); chk("R7 status with mask off", v, 1);
    chk("R7 irq masked", {31'b0, irq_o}, 0);
    wr(A_MASK, 32'd1); idle(1);
    chk("R7 irq unmasked", {31'b0, irq_o}, 1);

    // R8 write zero no effect, write one clears
    wr(A_CLR, 32'd0); idle(2);
    rd(A_STAT, v); chk("R8 write zero ignored", v, 1);
    wr(A_CLR, 32'hFFFF_FFFF); idle(2);
    rd(A_STAT, v); chk("R8 write one clears", v, 0);
    chk("R8 irq drops", {31'b0, irq_o}, 0);

    // R8 set wins over clear on the same edge
    wr(A_MATCH, 32'd1); idle(1);
    tick_i = 1; idle(3);
    wr(A_CLR, 32'd1);
    idle(2); tick_i = 0; idle(6);
    rd(A_CNT, v);  chk("R2 count before race", v, 1);
    rd(A_STAT, v); chk("R8 set beats clear", v, 1);

    // R4 load beats tick on the same edge
    wr(A_CLR, 32'd1);
    tick_i = 1; idle(2);
    wr(A_LOAD, 32'd500);
    idle(4); tick_i = 0; idle(6);
    rd(A_CNT, v); chk("R4 load wins over tick", v, 500);
    tick();
    rd(A_CNT, v); chk("R4 counting resumes", v, 501);

    report();
  end
endmodule